// File: doc/BRIEF.md
# Double-Edge PWM Generator with Latched Match Updates

This block generates a set of pulse-width-modulated outputs that all share one repetition rate. A prescaler divides the clock into timer ticks. A counter advances on each tick. Match slot 0 holds the period. Each channel owns two further match slots, called its A and B edges. A channel works either in single-edge mode, where the output rises at count zero and falls at A, or in double-edge mode, where the pulse lies between A and B. A double-edge pulse can be positive-going or negative-going.

Software writes match values into shadow copies. A shadow value does not change the waveform until software sets that slot's release bit. Once released, it is copied into the live match set at the moment the counter wraps from the period back to zero. Because of this, an update can never cut a pulse short or produce a stray edge. When PWM operation is off, the outputs stay low and the counter runs as a plain timer over its whole range.

Configuration uses a simple one-cycle register write port. The current count and the channel outputs are the only results.

Top module: `pwm_dual_edge`

## Requirements
- R1: After reset the count is 0, every output is low, all match values and the prescale value are 0, no release is pending, and both counting and PWM operation are disabled.
- R2: The register at address NMATCH holds a prescale value P. While counting is enabled, the count advances once every P+1 clocks. While counting is disabled, the count holds its value.
- R3: Each timer tick raises the count by exactly one, except when R4 or R10 applies.
- R4: With PWM on, the tick that finds the count equal to the live period (slot 0) takes the count to 0. Every channel repeats at that rate, so the count never exceeds the period.
- R5: A single-edge channel (mode bit clear) is high from count 0 and low from count A. With A = 0 it is always low. With A greater than the period it is always high.
- R6: A positive double-edge channel (dual bit set, low bit clear) goes high when the count reaches A and low when it reaches B. If A equals B, low wins.
- R7: A negative double-edge channel (dual bit and low bit both set) drives the inverse of the R6 waveform, so it idles high.
- R8: A write to match address m (0 to NMATCH-1; the channel c edges are at 1+2c for A and 2+2c for B) changes only the shadow copy. The waveform is unchanged while release bit m is clear.
- R9: Register NMATCH+3 sets release bits: a 1 in bit m marks slot m. At the wrap tick, each released slot is copied to its live slot and takes effect from count 0 of the new period. Its release bit then clears, so a later shadow write without a new release has no effect.
- R10: Register NMATCH+1 has bit 0 for count enable and bit 1 for PWM enable. With PWM off, all outputs are low and the counter ignores the period, wrapping from all ones to 0.
- R11: Register NMATCH+2 holds per-channel dual bits in [NCH-1:0] and low bits in [2*NCH-1:NCH]. Writes to addresses above NMATCH+3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | AW | Register address |
| wr_data | input | CNT_W | Register write data |
| tc_value | output | CNT_W | Current timer count |
| pwm_out | output | NCH | Channel outputs |

## Verification
The bench builds the block with CNT_W = 8 and NCH = 3. The 8-bit counter lets a timer-mode run cross the all-ones to zero wrap within a few hundred clocks, which a 32-bit default could never reach. Three channels are enough to run single-edge, positive and negative double-edge side by side within one period. A small period of 9 with prescale 1 keeps each measured window at 20 clocks. This makes the A = 0, A beyond the period, A = B and period-shrink cases cheap to measure across whole periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        EDGE_SINGLE    = 2'd0,
        EDGE_DUAL_HIGH = 2'd1,
        EDGE_DUAL_LOW  = 2'd2
    } edge_mode_e;

    typedef struct packed {
        logic set;
        logic clr;
    } edge_hit_t;

    // control register bit positions
    localparam int CTRL_COUNT_BIT = 0;
    localparam int CTRL_PWM_BIT   = 1;

    // register offsets past the match slots
    localparam int OFF_PRESCALE = 0;
    localparam int OFF_CTRL     = 1;
    localparam int OFF_MODE     = 2;
    localparam int OFF_RELEASE  = 3;
    localparam int EXTRA_REGS   = 4;

    function automatic int match_slots(input int nch);
        return 1 + 2 * nch;
    endfunction

    function automatic edge_mode_e decode_mode(input logic dual, input logic low);
        if (!dual)
            return EDGE_SINGLE;
        else if (low)
            return EDGE_DUAL_LOW;
        else
            return EDGE_DUAL_HIGH;
    endfunction

    // clear takes priority over set when both land on the same count
    function automatic logic apply_hit(input logic cur, input edge_hit_t h);
        if (h.clr)
            return 1'b0;
        else if (h.set)
            return 1'b1;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (!run || tick)
            div_q <= '0;
        else
            div_q <= div_q + W'(1);
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pwm_en,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         wrap
);
    logic [W-1:0] count_q;

    assign wrap       = tick && pwm_en && (count_q == period);
    assign count_next = wrap ? '0 : count_q + W'(1);
    assign count      = count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (tick)
            count_q <= count_next;
    end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int W = 32,
    parameter int N = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic [N-1:0]        rel_set,
    input  logic                wrap,
    output logic [N-1:0][W-1:0] eff,
    output logic [N-1:0][W-1:0] active,
    output logic [N-1:0]        pending
);
    logic [N-1:0][W-1:0] shadow_q;
    logic [N-1:0][W-1:0] live_q;
    logic [N-1:0]        rel_q;

    for (genvar m = 0; m < N; m++) begin : g_slot
        logic take;
        assign take   = wrap && rel_q[m];
        // values used by the channels on the tick that copies them
        assign eff[m] = take ? shadow_q[m] : live_q[m];

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[m] <= '0;
                live_q[m]   <= '0;
                rel_q[m]    <= 1'b0;
            end else begin
                if (wr_sel[m])
                    shadow_q[m] <= wr_data;
                if (take)
                    live_q[m] <= shadow_q[m];
                rel_q[m] <= (rel_q[m] && !take) || rel_set[m];
            end
        end
    end

    assign active  = live_q;
    assign pending = rel_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm_en,
    input  logic         tick,
    input  logic [W-1:0] count_next,
    input  logic [W-1:0] edge_a,
    input  logic [W-1:0] edge_b,
    input  edge_mode_e   mode,
    output logic         pin
);
    edge_hit_t hit;
    logic      level_q;

    always_comb begin
        if (mode == EDGE_SINGLE) begin
            hit.set = (count_next == '0);
            hit.clr = (count_next == edge_a);
        end else begin
            hit.set = (count_next == edge_a);
            hit.clr = (count_next == edge_b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwm_en)
            level_q <= 1'b0;
        else if (tick)
            level_q <= apply_hit(level_q, hit);
    end

    assign pin = pwm_en && (level_q ^ (mode == EDGE_DUAL_LOW));
endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
    import pwm_pkg::*;
#(
    parameter  int CNT_W  = 32,
    parameter  int NCH    = 4,
    localparam int NMATCH = 1 + 2 * NCH,
    localparam int AW     = $clog2(NMATCH + EXTRA_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] tc_value,
    output logic [NCH-1:0]   pwm_out
);
    localparam logic [AW-1:0] A_PRESCALE = AW'(NMATCH + OFF_PRESCALE);
    localparam logic [AW-1:0] A_CTRL     = AW'(NMATCH + OFF_CTRL);
    localparam logic [AW-1:0] A_MODE     = AW'(NMATCH + OFF_MODE);
    localparam logic [AW-1:0] A_RELEASE  = AW'(NMATCH + OFF_RELEASE);

    logic [CNT_W-1:0] prescale_q;
    logic             cnt_en_q;
    logic             pwm_en_q;
    logic [NCH-1:0]   dual_q;
    logic [NCH-1:0]   low_q;

    logic                     tick;
    logic                     wrap;
    logic [CNT_W-1:0]         count_next;
    logic [NMATCH-1:0]        match_we;
    logic [NMATCH-1:0]        rel_set;
    logic [NMATCH-1:0]        rel_pend;
    logic [NMATCH-1:0][CNT_W-1:0] match_eff;
    logic [NMATCH-1:0][CNT_W-1:0] match_act;

    // ---------------- register write decode ----------------
    for (genvar m = 0; m < NMATCH; m++) begin : g_we
        assign match_we[m] = wr_en && (wr_addr == AW'(m));
    end

    assign rel_set = (wr_en && wr_addr == A_RELEASE) ? wr_data[NMATCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q <= '0;
            cnt_en_q   <= 1'b0;
            pwm_en_q   <= 1'b0;
            dual_q     <= '0;
            low_q      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PRESCALE: prescale_q <= wr_data;
                A_CTRL: begin
                    cnt_en_q <= wr_data[CTRL_COUNT_BIT];
                    pwm_en_q <= wr_data[CTRL_PWM_BIT];
                end
                A_MODE: begin
                    dual_q <= wr_data[NCH-1:0];
                    low_q  <= wr_data[2*NCH-1:NCH];
                end
                default: ;
            endcase
        end
    end

    // ---------------- timebase ----------------
    pwm_prescaler #(.W(CNT_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (cnt_en_q),
        .limit (prescale_q),
        .tick  (tick)
    );

    pwm_timebase #(.W(CNT_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pwm_en     (pwm_en_q),
        .period     (match_act[0]),
        .count      (tc_value),
        .count_next (count_next),
        .wrap       (wrap)
    );

    // ---------------- match storage ----------------
    pwm_match_bank #(.W(CNT_W), .N(NMATCH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (match_we),
        .wr_data (wr_data),
        .rel_set (rel_set),
        .wrap    (wrap),
        .eff     (match_eff),
        .active  (match_act),
        .pending (rel_pend)
    );

    // ---------------- channels ----------------
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        edge_mode_e ch_mode;
        assign ch_mode = decode_mode(dual_q[c], low_q[c]);

        pwm_channel #(.W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .pwm_en     (pwm_en_q),
            .tick       (tick),
            .count_next (count_next),
            .edge_a     (match_eff[1 + 2*c]),
            .edge_b     (match_eff[2 + 2*c]),
            .mode       (ch_mode),
            .pin        (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_dual_edge_chk.sv
module pwm_dual_edge_chk #(
    parameter int W = 32,
    parameter int N = 9
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                wrap,
    input logic [W-1:0]        tc,
    input logic [N-1:0][W-1:0] active,
    input logic [N-1:0]        pending,
    input logic [N-1:0]        rel_set
);
    // R2: no tick, no movement of the count
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tc));

    // R3: ordinary tick advances by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap) |=> (tc == $past(tc) + W'(1)));

    // R4: a wrap returns the count to zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (tc == '0));

    // R8: live match values change only on a wrap
    a_r8_live_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active));

    // R9: release bits consumed by a wrap are cleared unless set again
    a_r9_release_consumed: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ((pending & $past(pending) & ~$past(rel_set)) == '0));
endmodule

bind pwm_dual_edge pwm_dual_edge_chk #(.W(CNT_W), .N(NMATCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wrap    (wrap),
    .tc      (tc_value),
    .active  (match_act),
    .pending (rel_pend),
    .rel_set (rel_set)
);

// File: tb/pwm_dual_edge_test.sv
module pwm_dual_edge_test;
    localparam int W    = 8;
    localparam int NC   = 3;
    localparam int NM   = 1 + 2 * NC;
    localparam int AW   = $clog2(NM + 4);
    localparam int MASK = (1 << W) - 1;
    localparam int A_PRE = NM, A_CTRL = NM + 1, A_MODE = NM + 2, A_REL = NM + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  tc;
    logic [NC-1:0] out;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit finished = 0;

    pwm_dual_edge #(.CNT_W(W), .NCH(NC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tc_value(tc), .pwm_out(out)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_pre, m_cnt, m_lim;
    bit m_cen, m_pen;
    int m_sh[NM];
    int m_ac[NM];
    bit m_rel[NM];
    bit m_dual[NC], m_low[NC], m_lvl[NC];

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_lim = 0; m_cen = 0; m_pen = 0;
            foreach (m_sh[i]) begin m_sh[i] = 0; m_ac[i] = 0; m_rel[i] = 0; end
            foreach (m_lvl[i]) begin m_lvl[i] = 0; m_dual[i] = 0; m_low[i] = 0; end
        end else begin
            bit t, w;
            int nxt;
            int e[NM];
            t = m_cen && (m_pre >= m_lim);
            w = t && m_pen && (m_cnt == m_ac[0]);
            foreach (e[i]) e[i] = (w && m_rel[i]) ? m_sh[i] : m_ac[i];
            nxt = w ? 0 : ((m_cnt + 1) & MASK);
            for (int c = 0; c < NC; c++) begin
                int a, b;
                bit up, dn;
                a = e[1 + 2*c]; b = e[2 + 2*c];
                if (m_dual[c]) begin up = (nxt == a); dn = (nxt == b); end
                else begin up = (nxt == 0); dn = (nxt == a); end
                if (!m_pen) m_lvl[c] = 0;
                else if (t) m_lvl[c] = dn ? 1'b0 : (up ? 1'b1 : m_lvl[c]);
            end
            if (!m_cen || t) m_pre = 0; else m_pre = m_pre + 1;
            if (t) m_cnt = nxt;
            for (int i = 0; i < NM; i++)
                if (w && m_rel[i]) begin m_ac[i] = m_sh[i]; m_rel[i] = 0; end
            if (wr_en) begin
                int ad;
                ad = int'(wr_addr);
                if (ad < NM) m_sh[ad] = int'(wr_data);
                else if (ad == A_PRE) m_lim = int'(wr_data);
                else if (ad == A_CTRL) begin m_cen = wr_data[0]; m_pen = wr_data[1]; end
                else if (ad == A_MODE)
                    for (int c = 0; c < NC; c++) begin
                        m_dual[c] = wr_data[c]; m_low[c] = wr_data[NC + c];
                    end
                else if (ad == A_REL)
                    for (int i = 0; i < NM; i++) if (wr_data[i]) m_rel[i] = 1;
            end
        end
    end

    function automatic int model_out();
        int v = 0;
        for (int c = 0; c < NC; c++)
            if (m_pen && (m_lvl[c] ^ (m_dual[c] && m_low[c]))) v |= (1 << c);
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({cur_req, " count"}, int'(tc), m_cnt);
            check({cur_req, " outputs"}, int'(out), model_out());
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        int prev;
        bit done;
        prev = int'(tc); done = 0;
        while (!done) begin
            @(negedge clk);
            if (tc == 0 && prev != 0) done = 1;
            prev = int'(tc);
        end
    endtask

    // counts high samples per channel over n clocks beginning now
    task automatic measure(input int n, output int hi[NC]);
        foreach (hi[i]) hi[i] = 0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            for (int c = 0; c < NC; c++) hi[c] += int'(out[c]);
        end
    endtask

    task automatic release_safe(input int mask);
        wait_start();
        repeat (3) @(negedge clk);
        wr(A_REL, mask);
        wait_start();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int hi[NC];
        int t0, t1, mx;
        bit saw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 count after reset", int'(tc), 0);
        check("R1 outputs after reset", int'(out), 0);

        // R2 / R3 prescaled counting
        cur_req = "R2";
        wr(A_PRE, 2);
        wr(A_CTRL, 1);
        repeat (5) @(negedge clk);
        t0 = int'(tc);
        repeat (30) @(negedge clk);
        t1 = int'(tc);
        check("R2 R3 ticks in 30 clocks at prescale 2", (t1 - t0) & MASK, 10);
        wr(A_CTRL, 0);
        repeat (3) @(negedge clk);
        t0 = int'(tc);
        repeat (20) @(negedge clk);
        check("R2 count holds while disabled", int'(tc), t0);

        // R10 timer mode wraps over the full range, outputs low
        cur_req = "R10";
        wr(A_PRE, 0);
        wr(A_CTRL, 1);
        saw = 0; mx = 0;
        t0 = int'(tc);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (t0 == MASK && tc == 0) saw = 1;
            if (out != 0) mx = 1;
            t0 = int'(tc);
        end
        check("R10 timer wraps from all ones to zero", int'(saw), 1);
        check("R10 outputs low in timer mode", mx, 0);

        // R11 configuration: period 9, ch0 single A=4, ch1 +dual 2..7, ch2 -dual 3..8
        cur_req = "R11";
        wr(0, 9); wr(1, 4); wr(2, 0); wr(3, 2); wr(4, 7); wr(5, 3); wr(6, 8);
        wr(A_MODE, 8'h26);
        wr(12, 8'hFF);            // unmapped address, must change nothing
        wr(A_PRE, 1);
        wr(A_REL, 8'h7F);
        wr(A_CTRL, 3);
        cur_req = "R5";
        wait_start(); wait_start(); wait_start();
        measure(20, hi);
        check("R5 single-edge high clocks", hi[0], 8);
        check("R6 positive double-edge high clocks", hi[1], 10);
        check("R7 negative double-edge high clocks", hi[2], 10);

        // R8 shadow write without release has no effect
        cur_req = "R8";
        wr(1, 6);
        wait_start(); wait_start();
        measure(20, hi);
        check("R8 unreleased shadow ignored", hi[0], 8);

        // R9 release applies at the next period start
        cur_req = "R9";
        release_safe(8'h02);
        measure(20, hi);
        check("R9 released value in effect", hi[0], 12);
        wr(1, 1);
        wait_start(); wait_start();
        measure(20, hi);
        check("R9 release bit self-cleared", hi[0], 12);

        // R5 boundaries
        cur_req = "R5";
        wr(1, 0);
        release_safe(8'h02);
        measure(20, hi);
        check("R5 A=0 always low", hi[0], 0);
        wr(1, 200);
        release_safe(8'h02);
        measure(20, hi);
        check("R5 A beyond period always high", hi[0], 20);

        // R6 equal edges: clear wins
        cur_req = "R6";
        wr(3, 5); wr(4, 5);
        release_safe(8'h18);
        measure(20, hi);
        check("R6 A equals B stays low", hi[1], 0);

        // R4 period shrink
        cur_req = "R4";
        wr(0, 4);
        release_safe(8'h01);
        mx = 0;
        for (int k = 0; k < 20; k++) begin
            if (int'(tc) > mx) mx = int'(tc);
            @(negedge clk);
        end
        check("R4 count peaks at new period", mx, 4);

        // R10 PWM off forces outputs low
        cur_req = "R10";
        wr(A_CTRL, 1);
        mx = 0;
        repeat (20) begin
            @(negedge clk);
            if (out != 0) mx = 1;
        end
        check("R10 outputs low after PWM disabled", mx, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule